// File: doc/BRIEF.md
# Command Packet Descriptor Parser

This block reads one command packet for a storage channel out of memory through a byte-wide read port. It checks the packet and latches the fields that a channel engine needs. It then walks the packet's scatter-gather table and hands each (address, length) pair downstream on a ready/valid stream. A controller writes a packet base address and pulses `start`. The parser fetches the fixed header bytes, with one read outstanding at a time and one cycle of read latency. It then either flags the packet as malformed or streams the table entries, and it ends with a `done` pulse.

Every multi-byte field in the packet is little-endian. The header has two tagged control sections. The first carries host flags, the total transfer size, the entry count and a 64-bit pointer to the table. The second carries device flags. The table pointer is taken from the packet itself, so the table may sit anywhere in memory. It does not have to follow the 64-byte packet slot. Moving the data, the link layer and bus arbitration belong to other blocks.

Top module: `cpp_parser`

## Requirements
- R1: After reset `busy`, `done`, `fmt_err`, `sg_valid` and `mem_rd_en` are all 0.
- R2: The header is accepted only when byte 0 is 0x01 and byte 24 is 0x02. The flag outputs are decoded as follows:
  - Byte 1 bit 0 drives `dir_out`, bit 3 drives `data_pkt`, bit 4 drives `irq_en` and bit 5 drives `pkt_valid`.
  - Byte 28 bit 2 drives `dma_mode` and bit 3 drives `lba48`.
  - These outputs are updated when the header is checked and are held until the next packet's header is checked.
- R3: `total_bytes` equals bytes 4..7 of the packet (little-endian). `entry_count` equals bytes 8..11 (little-endian).
- R4: Entry k is read at the table pointer (bytes 16..23, little-endian, low ADDR_W bits used) plus 16*k. Within the entry, bytes 0..7 form `sg_addr` and bytes 8..11 form `sg_len`, both little-endian.
- R5: Exactly `entry_count` entries are emitted, strictly in table order. `sg_last` is 1 only on the final entry.
- R6: While `sg_valid` is 1 and `sg_ready` is 0, `sg_valid`, `sg_addr`, `sg_len` and `sg_last` hold their values. No entry is lost or repeated.
- R7: If byte 0 is not 0x01 or byte 24 is not 0x02, the parser emits no entry, gives a one-cycle `fmt_err` pulse and returns to idle.
- R8: A packet whose valid flag (byte 1 bit 5) is 0 emits no entry and gives a one-cycle `fmt_err` pulse.
- R9: An entry count of zero gives a `fmt_err` pulse when the data flag (byte 1 bit 3) is 1. When the data flag is 0, it instead gives a `done` pulse with no entries.
- R10: `done` is a one-cycle pulse in the cycle after the last entry's handshake. `busy` is 0 from that cycle on.
- R11: A `start` pulse while `busy` is 1 is ignored. The packet in progress completes unchanged and no second packet is parsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin parsing the packet at `pkt_base` (taken only when idle) |
| pkt_base | input | ADDR_W | Byte address of the packet |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | A packet is being parsed |
| done | output | 1 | One-cycle pulse: packet finished without error |
| fmt_err | output | 1 | One-cycle pulse: packet rejected as malformed |
| dir_out | output | 1 | Host flag: data direction out (write) |
| data_pkt | output | 1 | Host flag: data packet |
| irq_en | output | 1 | Host flag: interrupt on completion |
| pkt_valid | output | 1 | Host flag: packet valid |
| dma_mode | output | 1 | Device flag: DMA rather than PIO |
| lba48 | output | 1 | Device flag: 48-bit addressing |
| total_bytes | output | 32 | Total transfer byte count |
| entry_count | output | 32 | Number of scatter-gather entries |
| sg_valid | output | 1 | Entry stream valid |
| sg_ready | input | 1 | Entry stream ready |
| sg_addr | output | 64 | Entry buffer address |
| sg_len | output | 32 | Entry buffer length |
| sg_last | output | 1 | Current entry is the final one |

## Verification
The bench builds the parser with ADDR_W = 12, which gives a 4 KiB byte memory that the bench models directly. In that space a packet and its table can be placed both contiguously and far apart, so the bench can show that the pointer inside the packet, not the slot size, locates the table. Entry counts up to six keep each packet short. This leaves room for many random packets with random backpressure, plus directed cases: bad tags, a clear valid flag, zero entries with and without the data flag, and a restart attempt while busy.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHECK,
    ST_ENT,
    ST_EMIT
  } cpp_state_t;

  typedef struct packed {
    logic dir_out;
    logic data_pkt;
    logic irq_en;
    logic pkt_valid;
    logic dma_mode;
    logic lba48;
  } cpp_flags_t;

  localparam logic [7:0] HOST_TAG   = 8'h01;
  localparam logic [7:0] DEV_TAG    = 8'h02;
  localparam int         HDR_BYTES  = 29;   // bytes 0..28 carry every decoded field
  localparam int         ENT_BYTES  = 12;   // address + length; trailing pad unread
  localparam int         ENT_STRIDE = 16;
  localparam int         SEQ_CNT_W  = 5;

  // byte offsets inside the header image
  localparam int OFS_HTAG  = 0;
  localparam int OFS_HFLG  = 1;
  localparam int OFS_TOTAL = 4;
  localparam int OFS_COUNT = 8;
  localparam int OFS_TBL   = 16;
  localparam int OFS_DTAG  = 24;
  localparam int OFS_DFLG  = 28;
endpackage

// File: rtl/cpp_read_seq.sv
// Issues a run of consecutive byte reads and tags each returned byte with its index.
module cpp_read_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_base,
  input  logic [CNT_W-1:0]  go_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rv,
  output logic [CNT_W-1:0]  ridx,
  output logic              rlast
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q, len_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      base_q   <= '0;
      rv       <= 1'b0;
      ridx     <= '0;
    end else begin
      rv   <= active_q;
      ridx <= cnt_q;
      if (go) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        len_q    <= go_len;
        base_q   <= go_base;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == len_q - 1'b1) active_q <= 1'b0;
      end
    end
  end

  assign rd_en   = active_q;
  assign rd_addr = base_q + ADDR_W'(cnt_q);
  assign rlast   = rv && (ridx == len_q - 1'b1);
endmodule

// File: rtl/cpp_byte_gather.sv
// Small byte store written by index; read out as one little-endian flat vector.
module cpp_byte_gather #(
  parameter int NBYTES = 12,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [7:0]          din,
  output logic [8*NBYTES-1:0] flat
);
  logic [7:0] store_q [NBYTES];

  always_ff @(posedge clk) begin
    if (we && (idx < IDX_W'(NBYTES))) store_q[idx] <= din;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign flat[8*g +: 8] = store_q[g];
  end
endmodule

// File: rtl/cpp_parser.sv
module cpp_parser
  import cpp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pkt_base,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              fmt_err,
  output logic              dir_out,
  output logic              data_pkt,
  output logic              irq_en,
  output logic              pkt_valid,
  output logic              dma_mode,
  output logic              lba48,
  output logic [31:0]       total_bytes,
  output logic [31:0]       entry_count,
  output logic              sg_valid,
  input  logic              sg_ready,
  output logic [63:0]       sg_addr,
  output logic [31:0]       sg_len,
  output logic              sg_last
);
  localparam int HDR_W = 8 * HDR_BYTES;
  localparam int ENT_W = 8 * ENT_BYTES;

  cpp_state_t state_q, state_d;
  cpp_flags_t flags_q, flags_dec;

  logic [31:0]       total_q, count_q, eidx_q;
  logic [ADDR_W-1:0] eaddr_q;
  logic              sg_valid_q, done_q, err_q;

  logic                 go;
  logic [ADDR_W-1:0]    go_base;
  logic [SEQ_CNT_W-1:0] go_len;
  logic                 rv, rlast;
  logic [SEQ_CNT_W-1:0] ridx;
  logic [HDR_W-1:0]     hdr_vec;
  logic [ENT_W-1:0]     ent_vec;

  cpp_read_seq #(.ADDR_W(ADDR_W), .CNT_W(SEQ_CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .go_base(go_base), .go_len(go_len),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .rv(rv), .ridx(ridx), .rlast(rlast)
  );

  cpp_byte_gather #(.NBYTES(HDR_BYTES), .IDX_W(SEQ_CNT_W)) u_hdr (
    .clk(clk), .we(rv && state_q == ST_HDR), .idx(ridx), .din(mem_rd_data), .flat(hdr_vec)
  );

  cpp_byte_gather #(.NBYTES(ENT_BYTES), .IDX_W(SEQ_CNT_W)) u_ent (
    .clk(clk), .we(rv && state_q == ST_ENT), .idx(ridx), .din(mem_rd_data), .flat(ent_vec)
  );

  // header field decode
  logic [7:0]        h_tag, h_flg, d_tag, d_flg;
  logic [31:0]       h_total, h_count;
  logic [ADDR_W-1:0] h_tbl;
  logic              hdr_bad, last_ent;

  assign h_tag   = hdr_vec[8*OFS_HTAG +: 8];
  assign h_flg   = hdr_vec[8*OFS_HFLG +: 8];
  assign h_total = hdr_vec[8*OFS_TOTAL +: 32];
  assign h_count = hdr_vec[8*OFS_COUNT +: 32];
  assign h_tbl   = hdr_vec[8*OFS_TBL +: ADDR_W];
  assign d_tag   = hdr_vec[8*OFS_DTAG +: 8];
  assign d_flg   = hdr_vec[8*OFS_DFLG +: 8];

  assign flags_dec.dir_out   = h_flg[0];
  assign flags_dec.data_pkt  = h_flg[3];
  assign flags_dec.irq_en    = h_flg[4];
  assign flags_dec.pkt_valid = h_flg[5];
  assign flags_dec.dma_mode  = d_flg[2];
  assign flags_dec.lba48     = d_flg[3];

  assign hdr_bad  = (h_tag != HOST_TAG) || (d_tag != DEV_TAG) || !flags_dec.pkt_valid ||
                    (flags_dec.data_pkt && h_count == 32'd0);
  assign last_ent = (eidx_q == count_q - 32'd1);

  always_comb begin
    state_d = state_q;
    go      = 1'b0;
    go_base = eaddr_q + ADDR_W'(ENT_STRIDE);
    go_len  = SEQ_CNT_W'(ENT_BYTES);
    unique case (state_q)
      ST_IDLE: if (start) begin
        go      = 1'b1;
        go_base = pkt_base;
        go_len  = SEQ_CNT_W'(HDR_BYTES);
        state_d = ST_HDR;
      end
      ST_HDR:  if (rlast) state_d = ST_CHECK;
      ST_CHECK: begin
        if (hdr_bad || h_count == 32'd0) begin
          state_d = ST_IDLE;
        end else begin
          go      = 1'b1;
          go_base = h_tbl;
          state_d = ST_ENT;
        end
      end
      ST_ENT:  if (rlast) state_d = ST_EMIT;
      ST_EMIT: if (sg_ready) begin
        if (last_ent) state_d = ST_IDLE;
        else begin
          go      = 1'b1;
          state_d = ST_ENT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      flags_q    <= '0;
      total_q    <= '0;
      count_q    <= '0;
      eidx_q     <= '0;
      eaddr_q    <= '0;
      sg_valid_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        ST_CHECK: begin
          flags_q <= flags_dec;
          total_q <= h_total;
          count_q <= h_count;
          eidx_q  <= '0;
          eaddr_q <= h_tbl;
          err_q   <= hdr_bad;
          done_q  <= !hdr_bad && (h_count == 32'd0);
        end
        ST_ENT: if (rlast) sg_valid_q <= 1'b1;
        ST_EMIT: if (sg_ready) begin
          sg_valid_q <= 1'b0;
          if (last_ent) done_q <= 1'b1;
          else begin
            eidx_q  <= eidx_q + 32'd1;
            eaddr_q <= eaddr_q + ADDR_W'(ENT_STRIDE);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign fmt_err     = err_q;
  assign dir_out     = flags_q.dir_out;
  assign data_pkt    = flags_q.data_pkt;
  assign irq_en      = flags_q.irq_en;
  assign pkt_valid   = flags_q.pkt_valid;
  assign dma_mode    = flags_q.dma_mode;
  assign lba48       = flags_q.lba48;
  assign total_bytes = total_q;
  assign entry_count = count_q;
  assign sg_valid    = sg_valid_q;
  assign sg_addr     = ent_vec[63:0];
  assign sg_len      = ent_vec[95:64];
  assign sg_last     = sg_valid_q && last_ent;
endmodule

// File: rtl/cpp_parser_chk.sv
module cpp_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        fmt_err,
  input logic        mem_rd_en,
  input logic        sg_valid,
  input logic        sg_ready,
  input logic [63:0] sg_addr,
  input logic [31:0] sg_len,
  input logic        sg_last
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    sg_valid && !sg_ready |=> sg_valid && $stable(sg_addr) && $stable(sg_len) && $stable(sg_last));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !sg_valid);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> !fmt_err);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> !sg_valid && !busy);

  assert_end_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fmt_err}));

  assert_stream_busy_R5: assert property (@(posedge clk) disable iff (rst)
    sg_valid |-> busy);

  assert_reads_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);
endmodule

bind cpp_parser cpp_parser_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .fmt_err(fmt_err),
  .mem_rd_en(mem_rd_en), .sg_valid(sg_valid), .sg_ready(sg_ready),
  .sg_addr(sg_addr), .sg_len(sg_len), .sg_last(sg_last)
);

// File: tb/sim_cpp_parser.sv
`timescale 1ns/1ps
module sim_cpp_parser;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] pkt_base = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data = '0;
  logic          busy, done, fmt_err;
  logic          dir_out, data_pkt, irq_en, pkt_valid, dma_mode, lba48;
  logic [31:0]   total_bytes, entry_count;
  logic          sg_valid;
  logic          sg_ready = 1'b0;
  logic [63:0]   sg_addr;
  logic [31:0]   sg_len;
  logic          sg_last;

  cpp_parser #(.ADDR_W(AW)) u0 (.*);

  always #2.5 clk = ~clk;

  logic [7:0] mem [1 << AW];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected table contents
  logic [63:0] ex_a [8];
  logic [31:0] ex_l [8];

  task automatic wr_le(input int a, input longint unsigned v, input int n);
    for (int i = 0; i < n; i++) mem[(a + i) % (1 << AW)] = 8'(v >> (8 * i));
  endtask

  task automatic build(input int base, input logic [7:0] htag, input logic [7:0] hflg,
                       input logic [7:0] dtag, input logic [7:0] dflg, input logic [31:0] total,
                       input int cnt, input int tbl);
    for (int i = 0; i < 64; i++) mem[(base + i) % (1 << AW)] = 8'($urandom);
    mem[base]      = htag;
    mem[base + 1]  = hflg;
    wr_le(base + 4, total, 4);
    wr_le(base + 8, 32'(cnt), 4);
    wr_le(base + 16, 64'(tbl), 8);
    mem[base + 24] = dtag;
    mem[base + 28] = dflg;
    for (int k = 0; k < cnt && k < 8; k++) begin
      ex_a[k] = {$urandom, $urandom};
      ex_l[k] = $urandom;
      wr_le(tbl + 16 * k, ex_a[k], 8);
      wr_le(tbl + 16 * k + 8, ex_l[k], 4);
      wr_le(tbl + 16 * k + 12, 32'($urandom), 4);
    end
  endtask

  // flag word: {dir, data, irq, valid, dma, lba48}, from byte1 bits 0,3,4,5 and byte28 bits 2,3
  function automatic logic [5:0] exp_flags(input logic [7:0] hf, input logic [7:0] df);
    return {hf[0], hf[3], hf[4], hf[5], df[2], df[3]};
  endfunction

  // Drives one packet and scores the stream. mode: 0 expect done, 1 expect fmt_err.
  task automatic run(input int base, input int n_exp, input bit exp_err, input int rdy_pct,
                     input bit restart, input string tag);
    int  got = 0;
    bit  ended = 0, saw_err = 0, saw_done = 0;
    bit  hold = 0;
    logic [63:0] ha;
    logic [31:0] hl;
    @(negedge clk);
    start = 1'b1;
    pkt_base = AW'(base);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000 && !ended; c++) begin
      @(negedge clk);
      if (done)    begin saw_done = 1; ended = 1; end
      if (fmt_err) begin saw_err = 1;  ended = 1; end
      if (restart && c == 4) begin
        chk(busy, "R11", {tag, " busy at restart"}, 64'(busy), 1);
        start = 1'b1;
        pkt_base = AW'(base + 12'h400);
      end else start = 1'b0;
      if (hold) begin
        chk(sg_valid && sg_addr == ha && sg_len == hl, "R6", {tag, " held entry"}, sg_addr, ha);
      end
      sg_ready = (($urandom % 100) < 32'(rdy_pct));
      #1;
      hold = sg_valid && !sg_ready;
      ha = sg_addr;
      hl = sg_len;
      if (sg_valid && sg_ready) begin
        if (got < n_exp && got < 8) begin
          chk(sg_addr == ex_a[got], "R4", {tag, " entry addr"}, sg_addr, ex_a[got]);
          chk(sg_len == ex_l[got], "R4", {tag, " entry len"}, 64'(sg_len), 64'(ex_l[got]));
          chk(sg_last == (got == n_exp - 1), "R5", {tag, " last flag"}, 64'(sg_last),
              64'(got == n_exp - 1));
        end
        got++;
      end
    end
    start = 1'b0;
    sg_ready = 1'b0;
    chk(ended, "R10", {tag, " packet ended"}, 64'(ended), 1);
    chk(got == n_exp, "R5", {tag, " entry total"}, 64'(got), 64'(n_exp));
    if (exp_err) chk(saw_err && !saw_done, "R7", {tag, " fmt_err pulse"}, 64'(saw_err), 1);
    else         chk(saw_done && !saw_err, "R10", {tag, " done pulse"}, 64'(saw_done), 1);
    @(negedge clk);
    chk(!busy && !done && !fmt_err, "R10", {tag, " idle after end"},
        64'({busy, done, fmt_err}), 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(!busy && !sg_valid, "R11", {tag, " no second run"}, 64'({busy, sg_valid}), 0);
  endtask

  task automatic chk_fields(input logic [7:0] hf, input logic [7:0] df,
                            input logic [31:0] tot, input int cnt, input string tag);
    chk({dir_out, data_pkt, irq_en, pkt_valid, dma_mode, lba48} == exp_flags(hf, df), "R2",
        {tag, " flags"}, 64'({dir_out, data_pkt, irq_en, pkt_valid, dma_mode, lba48}),
        64'(exp_flags(hf, df)));
    chk(total_bytes == tot, "R3", {tag, " total"}, 64'(total_bytes), 64'(tot));
    chk(entry_count == 32'(cnt), "R3", {tag, " count"}, 64'(entry_count), 64'(cnt));
  endtask

  initial begin
    void'($urandom(20240611));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !fmt_err && !sg_valid && !mem_rd_en, "R1", "reset outputs",
        64'({busy, done, fmt_err, sg_valid, mem_rd_en}), 0);

    // contiguous table, all flags set, free-flowing stream
    build(12'h000, 8'h01, 8'h39, 8'h02, 8'h0C, 32'h0001_2345, 3, 12'h040);
    run(12'h000, 3, 0, 100, 0, "contig");
    chk_fields(8'h39, 8'h0C, 32'h0001_2345, 3, "contig");

    // table far from packet, read-only transfer, backpressure
    build(12'h100, 8'h01, 8'h28, 8'h02, 8'h04, 32'hDEAD_0200, 5, 12'hA30);
    run(12'h100, 5, 0, 30, 0, "remote");
    chk_fields(8'h28, 8'h04, 32'hDEAD_0200, 5, "remote");

    // R7 bad host tag
    build(12'h200, 8'h03, 8'h38, 8'h02, 8'h04, 32'd512, 2, 12'h240);
    run(12'h200, 0, 1, 100, 0, "R7 htag");
    // R7 bad device tag
    build(12'h200, 8'h01, 8'h38, 8'h07, 8'h04, 32'd512, 2, 12'h240);
    run(12'h200, 0, 1, 100, 0, "R7 dtag");
    // R8 valid clear
    build(12'h300, 8'h01, 8'h18, 8'h02, 8'h04, 32'd512, 2, 12'h340);
    run(12'h300, 0, 1, 100, 0, "R8 invalid");
    chk(pkt_valid == 1'b0, "R8", "valid flag shown", 64'(pkt_valid), 0);
    // R9 data with zero entries
    build(12'h300, 8'h01, 8'h28, 8'h02, 8'h04, 32'd0, 0, 12'h340);
    run(12'h300, 0, 1, 100, 0, "R9 data0");
    // R9 non-data with zero entries
    build(12'h300, 8'h01, 8'h20, 8'h02, 8'h00, 32'd0, 0, 12'h340);
    run(12'h300, 0, 0, 100, 0, "R9 nodata0");
    chk_fields(8'h20, 8'h00, 32'd0, 0, "R9 nodata0");

    // R11 start while busy; decoy packet at +0x400 would fail if parsed
    build(12'h500, 8'h01, 8'h20, 8'h07, 8'h00, 32'd0, 0, 12'h540);
    build(12'h100, 8'h01, 8'h39, 8'h02, 8'h08, 32'd4096, 4, 12'h140);
    run(12'h100, 4, 0, 60, 1, "R11 restart");

    // random packets
    for (int p = 0; p < 24; p++) begin
      int base = 256 * ($urandom % 8);
      int cnt  = 1 + ($urandom % 6);
      int tbl  = ($urandom % 2) ? base + 64 : 12'h900 + 16 * ($urandom % 16);
      logic [7:0] hf = 8'($urandom) | 8'h20;
      logic [7:0] df = 8'($urandom);
      logic [31:0] tot = $urandom;
      build(base, 8'h01, hf, 8'h02, df, tot, cnt, tbl);
      run(base, cnt, 0, 20 + ($urandom % 81), 0, "rand");
      chk_fields(hf, df, tot, cnt, "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule